// File: doc/BRIEF.md
# Asynchronous serial receiver with sticky error status

This block receives asynchronous serial frames from a single line, oversampled sixteen times per bit from a clock-enable produced by a simple integer divider. A frame has a start bit, then 7 or 8 data bits sent least significant bit first, an optional even or odd parity bit, and one or two stop bits. The receiver looks for a falling edge on the line, confirms the start bit at its middle, and takes every later bit at its middle.

Each finished frame is written into a data register. A clean frame raises a data-full flag. A frame with a bad stop bit or a bad parity bit is still written into the data register, but it raises a sticky framing or parity flag instead of the full flag. While either error flag is raised, the receiver ignores new frames. Software clears any flag by reading the status register while the flag shows 1 and then writing 0 to that flag's bit. A standby input, like reset, clears both error flags.

The registers are reached through a small port with an address, a read strobe, a write strobe, write data and registered read data.

Top module: `uart_rx_stat`

## Requirements
- R1: Data bits are sampled at the middle of each bit time, least significant bit first. With control bit 1 set to 1, 8 bits are taken. With it at 0, 7 bits are taken and bit 7 of the data register reads 0. The data register is at address 2.
- R2: A frame with a good stop bit and no parity error stores its byte and sets the full flag (status bit 0 at address 1).
- R3: When the first stop bit is sampled as 0, the framing flag (status bit 1) is set and the byte is still stored, but the full flag is not set.
- R4: With two stop bits selected (control bit 4 = 1), the second stop bit is not checked: a 0 in it raises no framing error.
- R5: With parity enabled (control bit 2 = 1; control bit 3 = 1 selects odd, 0 selects even), a wrong parity bit sets the parity flag (status bit 2), stores the byte and leaves the full flag clear. A frame that has both faults sets both flags.
- R6: While the framing or the parity flag is 1, start bits are ignored: a later frame changes neither the data register nor the status.
- R7: A status flag clears only when 0 is written to its bit after a status read that returned it as 1. Writing 0 without that read, or writing 1, leaves the flag unchanged.
- R8: With the enable (control bit 0) at 0, no frame is received. Clearing the enable leaves both error flags unchanged.
- R9: A one-cycle pulse on the standby input clears both error flags.
- R10: After reset, the control, status and data registers read 0. Read data for the addressed register appears in the cycle after the read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| standby | input | 1 | Clears both error flags while high |
| rx_line | input | 1 | Serial input line, idles high |
| reg_addr | input | 2 | Register address: 0 control, 1 status, 2 data |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |

## Verification
The hardest condition to reach from the ports is the clearing handshake under an error. A status read arms the clear, so any status check made after an error frame already performs the first half of it. To prove that a write of 0 without a prior read does nothing, the stimulus writes 0 to the status right after a faulty frame, before any read. It then sends a clean frame while the flag is still up, and only afterwards reads the status and data to see that both the flag and the byte stayed put. Random frames with random faults, formats and parity senses cover the remaining combinations, each one followed by a read-then-write-zero clear.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  localparam int REG_AW = 2;

  localparam logic [REG_AW-1:0] A_CTRL = 2'd0;
  localparam logic [REG_AW-1:0] A_STAT = 2'd1;
  localparam logic [REG_AW-1:0] A_DATA = 2'd2;

  // status bit positions
  localparam int ST_FULL = 0;
  localparam int ST_FERR = 1;
  localparam int ST_PERR = 2;

  typedef struct packed {
    logic two_stop;
    logic odd;
    logic par_en;
    logic eight;
    logic en;
  } rx_cfg_t;

  typedef enum logic [2:0] {
    S_IDLE,
    S_START,
    S_DATA,
    S_PAR,
    S_STOP,
    S_STOP2
  } rx_state_t;

endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout,
  output logic fall
);
  logic [STAGES:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= '1;
    else     sh <= {sh[STAGES-1:0], din};
  end

  assign dout = sh[STAGES-1];
  assign fall = sh[STAGES] & ~sh[STAGES-1];
endmodule

// File: rtl/uart_rx_tick.sv
module uart_rx_tick #(
  parameter int DIV = 8
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt == LAST) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
  import uart_rx_pkg::*;
#(
  parameter int OVS = 16,
  parameter int DW  = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          line,
  input  logic          fall,
  input  rx_cfg_t       cfg,
  input  logic          hold,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] done_data,
  output logic          done_ferr,
  output logic          done_perr
);
  localparam int CW = $clog2(OVS);
  localparam int BW = $clog2(DW);
  localparam logic [CW-1:0] MID  = CW'(OVS / 2 - 1);
  localparam logic [CW-1:0] LAST = CW'(OVS - 1);

  rx_state_t     state;
  logic [CW-1:0] cnt;
  logic [BW-1:0] bitn;
  logic [DW-1:0] sr;
  logic          par_acc;
  logic          perr_bit;
  logic [BW-1:0] last_bit;
  logic [DW-1:0] assembled;

  assign last_bit  = cfg.eight ? BW'(DW - 1) : BW'(DW - 2);
  assign assembled = cfg.eight ? sr : {1'b0, sr[DW-1:1]};
  assign busy      = (state != S_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      cnt       <= '0;
      bitn      <= '0;
      sr        <= '0;
      par_acc   <= 1'b0;
      perr_bit  <= 1'b0;
      done      <= 1'b0;
      done_data <= '0;
      done_ferr <= 1'b0;
      done_perr <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!cfg.en) begin
        state <= S_IDLE;
      end else begin
        case (state)
          S_IDLE: begin
            if (fall && !hold) begin
              state <= S_START;
              cnt   <= '0;
            end
          end
          S_START: begin
            if (tick) begin
              if (cnt == MID) begin
                cnt <= '0;
                if (!line) begin
                  state    <= S_DATA;
                  bitn     <= '0;
                  par_acc  <= 1'b0;
                  perr_bit <= 1'b0;
                end else begin
                  state <= S_IDLE;
                end
              end else begin
                cnt <= cnt + 1'b1;
              end
            end
          end
          S_DATA: begin
            if (tick) begin
              if (cnt == LAST) begin
                cnt     <= '0;
                sr      <= {line, sr[DW-1:1]};
                par_acc <= par_acc ^ line;
                bitn    <= bitn + 1'b1;
                if (bitn == last_bit) state <= cfg.par_en ? S_PAR : S_STOP;
              end else begin
                cnt <= cnt + 1'b1;
              end
            end
          end
          S_PAR: begin
            if (tick) begin
              if (cnt == LAST) begin
                cnt      <= '0;
                perr_bit <= line ^ par_acc ^ cfg.odd;
                state    <= S_STOP;
              end else begin
                cnt <= cnt + 1'b1;
              end
            end
          end
          S_STOP: begin
            if (tick) begin
              if (cnt == LAST) begin
                cnt       <= '0;
                done      <= 1'b1;
                done_data <= assembled;
                done_ferr <= ~line;
                done_perr <= cfg.par_en & perr_bit;
                state     <= cfg.two_stop ? S_STOP2 : S_IDLE;
              end else begin
                cnt <= cnt + 1'b1;
              end
            end
          end
          S_STOP2: begin
            // second stop bit only spaces frames; its value is not checked
            if (tick) begin
              if (cnt == LAST) begin
                cnt   <= '0;
                state <= S_IDLE;
              end else begin
                cnt <= cnt + 1'b1;
              end
            end
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/uart_rx_regs.sv
module uart_rx_regs
  import uart_rx_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              standby,
  input  logic [REG_AW-1:0] addr,
  input  logic              wr,
  input  logic              rd,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata,
  input  logic              done,
  input  logic [DW-1:0]     done_data,
  input  logic              done_ferr,
  input  logic              done_perr,
  output rx_cfg_t           cfg,
  output logic              full,
  output logic              ferr,
  output logic              perr
);
  logic [DW-1:0] ctrl_q;
  logic [DW-1:0] data_q;
  logic [2:0]    flags;
  logic [2:0]    armed;
  logic          wr_stat;
  logic          rd_stat;

  assign wr_stat = wr && (addr == A_STAT);
  assign rd_stat = rd && (addr == A_STAT);
  assign cfg     = rx_cfg_t'(ctrl_q[4:0]);
  assign full    = flags[ST_FULL];
  assign ferr    = flags[ST_FERR];
  assign perr    = flags[ST_PERR];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      data_q <= '0;
      flags  <= '0;
      armed  <= '0;
      rdata  <= '0;
    end else begin
      if (wr && (addr == A_CTRL)) ctrl_q <= wdata;

      // arm a flag when a status read returns it as 1
      if (rd_stat) armed <= armed | flags;

      // clear an armed flag on a write of 0 to its bit
      if (wr_stat) begin
        for (int b = 0; b < 3; b++) begin
          if (!wdata[b] && armed[b]) begin
            flags[b] <= 1'b0;
            armed[b] <= 1'b0;
          end
        end
      end

      if (done) begin
        data_q <= done_data;
        if (done_ferr || done_perr) begin
          if (done_ferr) flags[ST_FERR] <= 1'b1;
          if (done_perr) flags[ST_PERR] <= 1'b1;
        end else begin
          flags[ST_FULL] <= 1'b1;
        end
      end

      if (standby) begin
        flags[ST_FERR] <= 1'b0;
        flags[ST_PERR] <= 1'b0;
        armed[ST_FERR] <= 1'b0;
        armed[ST_PERR] <= 1'b0;
      end

      if (rd) begin
        case (addr)
          A_CTRL:  rdata <= ctrl_q;
          A_STAT:  rdata <= {{(DW-3){1'b0}}, flags};
          A_DATA:  rdata <= data_q;
          default: rdata <= '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/uart_rx_stat.sv
module uart_rx_stat
  import uart_rx_pkg::*;
#(
  parameter int CLK_DIV = 8,
  parameter int OVS     = 16,
  parameter int DW      = 8,
  parameter int SYNC    = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              standby,
  input  logic              rx_line,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata
);
  logic          line_s;
  logic          line_fall;
  logic          tick;
  rx_cfg_t       cfg;
  logic          full;
  logic          ferr;
  logic          perr;
  logic          busy;
  logic          done;
  logic [DW-1:0] done_data;
  logic          done_ferr;
  logic          done_perr;
  logic          done_err;
  logic          rx_en;
  logic          hold;

  assign done_err = done_ferr | done_perr;
  assign rx_en    = cfg.en;
  assign hold     = ferr | perr | done;

  uart_rx_sync #(.STAGES(SYNC)) sync_i (
    .clk  (clk),
    .rst  (rst),
    .din  (rx_line),
    .dout (line_s),
    .fall (line_fall)
  );

  uart_rx_tick #(.DIV(CLK_DIV)) tick_i (
    .clk  (clk),
    .rst  (rst),
    .tick (tick)
  );

  uart_rx_frame #(.OVS(OVS), .DW(DW)) frame_i (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .line      (line_s),
    .fall      (line_fall),
    .cfg       (cfg),
    .hold      (hold),
    .busy      (busy),
    .done      (done),
    .done_data (done_data),
    .done_ferr (done_ferr),
    .done_perr (done_perr)
  );

  uart_rx_regs #(.DW(DW)) regs_i (
    .clk       (clk),
    .rst       (rst),
    .standby   (standby),
    .addr      (reg_addr),
    .wr        (reg_wr),
    .rd        (reg_rd),
    .wdata     (reg_wdata),
    .rdata     (reg_rdata),
    .done      (done),
    .done_data (done_data),
    .done_ferr (done_ferr),
    .done_perr (done_perr),
    .cfg       (cfg),
    .full      (full),
    .ferr      (ferr),
    .perr      (perr)
  );
endmodule

// File: rtl/uart_rx_stat_chk.sv
module uart_rx_stat_chk
  import uart_rx_pkg::*;
#(
  parameter int DW = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              standby,
  input logic              reg_wr,
  input logic [REG_AW-1:0] reg_addr,
  input logic [DW-1:0]     reg_wdata,
  input logic              full,
  input logic              ferr,
  input logic              perr,
  input logic              busy,
  input logic              done,
  input logic              done_err,
  input logic              rx_en
);
  AST_FULL_ONLY_CLEAN: assert property (@(posedge clk) disable iff (rst)
    $rose(full) |-> ($past(done) && !$past(done_err))); // R2

  AST_ERR_SUPPRESS_FULL: assert property (@(posedge clk) disable iff (rst)
    (done && done_err) |=> !$rose(full)); // R3

  AST_NO_START_WHILE_ERR: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> !$past(ferr || perr)); // R6

  AST_NO_START_DISABLED: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(rx_en)); // R8

  AST_FLAGS_KEEP_ON_DISABLE: assert property (@(posedge clk) disable iff (rst)
    ($fell(rx_en) && !$past(done) && !$past(standby)) |-> ($stable(ferr) && $stable(perr))); // R8

  AST_FERR_CLEAR_NEEDS_WRITE: assert property (@(posedge clk) disable iff (rst)
    $fell(ferr) |-> ($past(standby) ||
                     $past(reg_wr && reg_addr == A_STAT && !reg_wdata[ST_FERR]))); // R7

  AST_PERR_CLEAR_NEEDS_WRITE: assert property (@(posedge clk) disable iff (rst)
    $fell(perr) |-> ($past(standby) ||
                     $past(reg_wr && reg_addr == A_STAT && !reg_wdata[ST_PERR]))); // R7

  AST_STANDBY_CLEARS: assert property (@(posedge clk) disable iff (rst)
    standby |=> (!ferr && !perr)); // R9
endmodule

bind uart_rx_stat uart_rx_stat_chk #(.DW(DW)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .standby   (standby),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .full      (full),
  .ferr      (ferr),
  .perr      (perr),
  .busy      (busy),
  .done      (done),
  .done_err  (done_err),
  .rx_en     (rx_en)
);

// File: tb/uart_rx_stat_tb_top.sv
module uart_rx_stat_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DIV        = 2;
  localparam int OVS        = 16;
  localparam int BIT_CLKS   = DIV * OVS;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       standby = 1'b0;
  logic       rx_line = 1'b1;
  logic [1:0] reg_addr = '0;
  logic       reg_wr = 1'b0;
  logic       reg_rd = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;

  int total = 0;
  int bad   = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_rx_stat #(.CLK_DIV(DIV), .OVS(OVS), .DW(8), .SYNC(2)) dut_i (
    .clk       (clk),
    .rst       (rst),
    .standby   (standby),
    .rx_line   (rx_line),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata)
  );

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic set_cfg(input bit en, input bit eight, input bit pe, input bit odd, input bit two);
    reg_write(2'd0, {3'b000, two, odd, pe, eight, en});
  endtask

  task automatic drive_bit(input logic v);
    rx_line = v;
    repeat (BIT_CLKS) @(negedge clk);
  endtask

  function automatic logic [7:0] stored(input logic [7:0] d, input bit eight);
    return eight ? d : {1'b0, d[6:0]};
  endfunction

  function automatic logic exp_status_bits(input bit dummy);
    return dummy;
  endfunction

  task automatic send_frame(input logic [7:0] d, input bit eight, input bit pe, input bit odd,
                            input bit two, input bit bad_par, input logic stop1, input logic stop2);
    logic [7:0] m;
    m = stored(d, eight);
    @(negedge clk);
    drive_bit(1'b0);
    for (int i = 0; i < (eight ? 8 : 7); i++) drive_bit(d[i]);
    if (pe) drive_bit((^m) ^ odd ^ bad_par);
    drive_bit(stop1);
    if (two) drive_bit(stop2);
    rx_line = 1'b1;
    repeat (2 * BIT_CLKS) @(negedge clk);
  endtask

  task automatic pulse_standby;
    @(negedge clk); standby = 1'b1;
    @(negedge clk); standby = 1'b0;
  endtask

  // status encoding: bit0 full, bit1 framing, bit2 parity
  function automatic logic [7:0] stat_of(input bit f, input bit fe, input bit pe);
    return {5'b0, pe, fe, f};
  endfunction

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] d;
    logic [7:0] last_data;
    void'($urandom(32'd4711));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);

    // R10 reset values
    reg_read(2'd0, d); check("R10 ctrl reset", d, 8'h00);
    reg_read(2'd1, d); check("R10 status reset", d, 8'h00);
    reg_read(2'd2, d); check("R10 data reset", d, 8'h00);

    // R1 R2 clean 8-bit frame
    set_cfg(1, 1, 0, 0, 0);
    reg_read(2'd0, d); check("R10 ctrl readback", d, 8'h03);
    send_frame(8'hA5, 1, 0, 0, 0, 0, 1, 1);
    reg_read(2'd1, d); check("R2 full set", d, stat_of(1, 0, 0));
    reg_read(2'd2, d); check("R1 data 8-bit", d, 8'hA5);
    reg_write(2'd1, 8'h00);
    reg_read(2'd1, d); check("R7 full cleared", d, 8'h00);

    // R1 7-bit even parity, good
    set_cfg(1, 0, 1, 0, 0);
    send_frame(8'hD3, 0, 1, 0, 0, 0, 1, 1);
    reg_read(2'd1, d); check("R5 good parity full", d, stat_of(1, 0, 0));
    reg_read(2'd2, d); check("R1 data 7-bit", d, 8'h53);
    reg_write(2'd1, 8'h00);

    // R5 odd parity error, then R7 write without read, R6 blocking
    set_cfg(1, 1, 1, 1, 0);
    send_frame(8'h3C, 1, 1, 1, 0, 1, 1, 1);
    reg_write(2'd1, 8'h00);                  // no prior read: no effect
    send_frame(8'h11, 1, 1, 1, 0, 0, 1, 1);  // must be ignored
    reg_read(2'd1, d); check("R7 write0 w/o read keeps perr", d, stat_of(0, 0, 1));
    reg_read(2'd2, d); check("R6 data kept while flag set", d, 8'h3C);
    reg_write(2'd1, 8'h07);
    reg_read(2'd1, d); check("R7 write1 keeps perr", d, stat_of(0, 0, 1));
    set_cfg(0, 1, 1, 1, 0);
    reg_read(2'd1, d); check("R8 disable keeps perr", d, stat_of(0, 0, 1));
    reg_write(2'd1, 8'h00);
    reg_read(2'd1, d); check("R7 read then write0 clears", d, 8'h00);

    // R8 disabled receiver ignores frames
    send_frame(8'h77, 1, 1, 1, 0, 0, 1, 1);
    reg_read(2'd1, d); check("R8 disabled status", d, 8'h00);
    reg_read(2'd2, d); check("R8 disabled data", d, 8'h3C);

    // R3 framing error, R9 standby
    set_cfg(1, 1, 0, 0, 0);
    send_frame(8'h5A, 1, 0, 0, 0, 0, 0, 1);
    reg_read(2'd1, d); check("R3 framing flag", d, stat_of(0, 1, 0));
    reg_read(2'd2, d); check("R3 data stored", d, 8'h5A);
    pulse_standby();
    reg_read(2'd1, d); check("R9 standby clears", d, 8'h00);

    // R5 both faults in one frame
    set_cfg(1, 1, 1, 0, 0);
    send_frame(8'hC1, 1, 1, 0, 0, 1, 0, 1);
    reg_read(2'd1, d); check("R5 both flags", d, stat_of(0, 1, 1));
    pulse_standby();

    // R4 second stop bit low is not an error
    set_cfg(1, 1, 0, 0, 1);
    send_frame(8'h96, 1, 0, 0, 1, 0, 1, 0);
    reg_read(2'd1, d); check("R4 second stop ignored", d, stat_of(1, 0, 0));
    reg_read(2'd2, d); check("R4 data", d, 8'h96);
    reg_write(2'd1, 8'h00);

    // random frames
    last_data = 8'h96;
    for (int n = 0; n < 40; n++) begin
      logic [7:0] rd8;
      bit eight, pe, odd, two, bp;
      logic s1, s2;
      bit fe, pf;
      rd8   = 8'($urandom);
      eight = 1'($urandom);
      pe    = 1'($urandom);
      odd   = 1'($urandom);
      two   = 1'($urandom);
      bp    = pe && ($urandom_range(0, 3) == 0);
      s1    = ($urandom_range(0, 4) != 0);
      s2    = 1'($urandom);
      fe    = !s1;
      pf    = bp;
      set_cfg(1, eight, pe, odd, two);
      send_frame(rd8, eight, pe, odd, two, bp, s1, s2);
      reg_read(2'd1, d); check("R2 R3 R5 random status", d, stat_of(!(fe || pf), fe, pf));
      reg_read(2'd2, d); check("R1 random data", d, stored(rd8, eight));
      reg_write(2'd1, 8'h00);
      reg_read(2'd1, d); check("R7 random clear", d, 8'h00);
      last_data = stored(rd8, eight);
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule